// File: doc/BRIEF.md
# Calendar alarm comparator with interrupt

This block watches a running calendar and raises an interrupt when the time reaches a programmed alarm. It holds four alarm slots: minute, hour, day of month and day of week. In each slot the top bit is a skip bit, so a slot takes part in the comparison only while that bit is clear. The time counters sit outside this block. They supply the current BCD fields and a strobe that pulses once each time the minute advances.

Matching is judged only on that strobe. When every slot that is taken into account equals the current field, a sticky alarm flag is set. Software clears the flag by writing zero to its bit, and writing one leaves it alone. An interrupt-enable bit gates the flag onto an active-low open-drain request, which appears here as a pull-down enable.

Register writes arrive on a valid/ready port. Ready is always high, so a write is taken in every cycle that valid is high and is applied at that clock edge. There is never any back-pressure. Read-back values are plain outputs.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset the flag, the interrupt enable and the pull-down are 0, and every alarm slot reads 0x80 (skipped).
- R2: A write to 0x09 (minute), 0x0A (hour), 0x0B (date) or 0x0C (weekday) stores bit 7 (the skip bit) and the value bits. The value bits are 6:0 for minute, 5:0 for hour and date, and 2:0 for weekday. Every other bit reads back 0.
- R3: On a strobe cycle, the flag becomes 1 at the clock edge if every slot with bit 7 = 0 equals its current field. A slot with bit 7 = 1 is ignored.
- R4: When all four slots have bit 7 = 1, the flag is never set.
- R5: With the strobe low, a matching time does not set the flag.
- R6: A write to 0x01 loads the interrupt enable from bit 1. If bit 3 is 0, the flag is cleared. If bit 3 is 1, the flag keeps its value. Address 0x01 reads back the flag at bit 3 and the enable at bit 1, with all other bits 0.
- R7: The pull-down output is 1 exactly while both the flag and the interrupt enable are 1.
- R8: If a strobe with a match falls in the same cycle as a write that clears the flag, the flag ends up 1.
- R9: If a strobe falls in the same cycle as an alarm slot write, the comparison uses the slot contents from before the write.
- R10: wr_ready is always 1. Writes to any address other than 0x01 and 0x09 to 0x0C change no readable state.
- R11: Once set, the flag stays 1 through later strobes that do not match, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe when the minute advances |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pull | output | 1 | Pull-down enable for the open-drain active-low interrupt |
| ctrl_rd | output | 8 | Control/status read-back (flag bit 3, enable bit 1) |
| alm_min_rd | output | 8 | Minute slot read-back |
| alm_hour_rd | output | 8 | Hour slot read-back |
| alm_date_rd | output | 8 | Date slot read-back |
| alm_wday_rd | output | 8 | Weekday slot read-back |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is the match-driven set of the flag and a software write that clears it. The second is the strobe comparison and a rewrite of an alarm slot. The bench provokes both on purpose: it raises the strobe with a matching time in the very cycle it clears the flag, and again in the cycle it rewrites the minute slot. It then judges, one cycle later, that the set wins and that the old slot value decided the match. A cycle-accurate behavioural model runs beside the design over these and a long stretch of narrowed random stimulus, and every output is compared on every clock.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int ALM_SLOTS = 4;
  localparam int ADDR_CTRL = 1;
  localparam int ADDR_ALM0 = 9;
  localparam int AF_BIT    = 3;
  localparam int AIE_BIT   = 1;

  // implemented value bits of each slot: minute, hour, date, weekday
  function automatic logic [31:0] slot_mask(input int s);
    case (s)
      0:       slot_mask = 32'h7F;
      1, 2:    slot_mask = 32'h3F;
      default: slot_mask = 32'h07;
    endcase
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alarm_irq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int SLOTS = ALM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  output logic [SLOTS-1:0][DW-1:0]    slot_q
);
  localparam int VW = DW - 1;
  localparam logic [DW-1:0] SKIP_RST = {1'b1, {VW{1'b0}}};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [VW-1:0] MASK = VW'(slot_mask(s));
    logic hit;
    assign hit = wr_fire && (wr_addr == AW'(ADDR_ALM0 + s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[s] <= SKIP_RST;
      else if (hit) slot_q[s] <= {wr_data[DW-1], wr_data[VW-1:0] & MASK};
    end
  end

  logic in_win;
  always_comb in_win = (wr_addr >= AW'(ADDR_ALM0)) && (wr_addr < AW'(ADDR_ALM0 + SLOTS));

  // R10: writes outside the slot window leave every slot untouched
  p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !in_win) |=> $stable(slot_q));
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alarm_irq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SLOTS = ALM_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0][DW-1:0]  slot_q,
  input  logic [SLOTS-1:0][DW-2:0]  cur_val,
  output logic                      match
);
  localparam int VW = DW - 1;
  logic [SLOTS-1:0] use_f, eq_f;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign use_f[s] = !slot_q[s][DW-1];
    assign eq_f[s]  = (slot_q[s][VW-1:0] == cur_val[s]);
  end

  assign match = (|use_f) && (&(eq_f | ~use_f));

  // R4: with every slot skipped there is never a match
  p_all_skipped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_f == '0) |-> !match);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic ctrl_we,
  input  logic wd_af,
  input  logic wd_aie,
  output logic af,
  output logic aie,
  output logic irq_pull
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af  <= 1'b0;
      aie <= 1'b0;
    end else begin
      if (ctrl_we) begin
        aie <= wd_aie;
        if (!wd_af) af <= 1'b0;
      end
      if (tick && match) af <= 1'b1;  // a set beats a same-cycle clear
    end
  end

  assign irq_pull = af & aie;

  // R3 and R8: a strobe with a match always leaves the flag set
  p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> af);
  // R6: a clearing write without a match clears the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wd_af && !(tick && match)) |=> !af);
  // R5 and R11: without a strobe or a control write the flag holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrl_we) |=> $stable(af));
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [5:0]    cur_date,
  input  logic [2:0]    cur_wday,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          alarm_flag,
  output logic          irq_pull,
  output logic [DW-1:0] ctrl_rd,
  output logic [DW-1:0] alm_min_rd,
  output logic [DW-1:0] alm_hour_rd,
  output logic [DW-1:0] alm_date_rd,
  output logic [DW-1:0] alm_wday_rd
);
  localparam int VW = DW - 1;

  logic                          wr_fire, ctrl_we, match, aie;
  logic [ALM_SLOTS-1:0][DW-1:0]  slot_q;
  logic [ALM_SLOTS-1:0][VW-1:0]  cur_val;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;
  assign ctrl_we  = wr_fire && (wr_addr == AW'(ADDR_CTRL));

  assign cur_val[0] = VW'(cur_min);
  assign cur_val[1] = VW'(cur_hour);
  assign cur_val[2] = VW'(cur_date);
  assign cur_val[3] = VW'(cur_wday);

  alm_regs #(.AW(AW), .DW(DW), .SLOTS(ALM_SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data), .slot_q(slot_q));

  alm_match #(.DW(DW), .SLOTS(ALM_SLOTS)) u_match (
    .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .cur_val(cur_val), .match(match));

  alm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
    .ctrl_we(ctrl_we), .wd_af(wr_data[AF_BIT]), .wd_aie(wr_data[AIE_BIT]),
    .af(alarm_flag), .aie(aie), .irq_pull(irq_pull));

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[AF_BIT]  = alarm_flag;
    ctrl_rd[AIE_BIT] = aie;
  end

  assign alm_min_rd  = slot_q[0];
  assign alm_hour_rd = slot_q[1];
  assign alm_date_rd = slot_q[2];
  assign alm_wday_rd = slot_q[3];

  // R7: the request line is never pulled without a pending flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> alarm_flag);
  // R10: the write port never stalls
  p_always_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

// File: tb/test_alarm_irq_unit.sv
`timescale 1ns/1ps
module test_alarm_irq_unit;
  logic       clk = 0, rst_n = 0, tick = 0, wr_valid = 0;
  logic [6:0] cur_min = 0;
  logic [5:0] cur_hour = 0, cur_date = 0;
  logic [2:0] cur_wday = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic       wr_ready, alarm_flag, irq_pull;
  logic [7:0] ctrl_rd, alm_min_rd, alm_hour_rd, alm_date_rd, alm_wday_rd;

  int checks = 0, errors = 0;
  logic [7:0] m_alm [4];
  bit m_af, m_aie;
  int mk [4] = '{8'h7F, 8'h3F, 8'h3F, 8'h07};

  always #2 clk = ~clk;

  alarm_irq_unit i_alarm_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_wday(cur_wday), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .alarm_flag(alarm_flag), .irq_pull(irq_pull),
    .ctrl_rd(ctrl_rd), .alm_min_rd(alm_min_rd), .alm_hour_rd(alm_hour_rd),
    .alm_date_rd(alm_date_rd), .alm_wday_rd(alm_wday_rd));

  task automatic chk(input string tag, input string nm, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "alarm_flag", {7'd0, alarm_flag}, {7'd0, m_af});
    chk(tag, "irq_pull", {7'd0, irq_pull}, {7'd0, m_af & m_aie});
    chk(tag, "ctrl_rd", ctrl_rd, {4'd0, m_af, 1'b0, m_aie, 1'b0});
    chk(tag, "alm_min_rd", alm_min_rd, m_alm[0]);
    chk(tag, "alm_hour_rd", alm_hour_rd, m_alm[1]);
    chk(tag, "alm_date_rd", alm_date_rd, m_alm[2]);
    chk(tag, "alm_wday_rd", alm_wday_rd, m_alm[3]);
    chk(tag, "wr_ready", {7'd0, wr_ready}, 8'd1);
  endtask

  function automatic bit model_match();
    int cur [4];
    bit any = 0, ok = 1;
    cur[0] = cur_min; cur[1] = cur_hour; cur[2] = cur_date; cur[3] = cur_wday;
    for (int i = 0; i < 4; i++)
      if (m_alm[i][7] == 1'b0) begin
        any = 1;
        if ((m_alm[i] & mk[i]) != cur[i]) ok = 0;
      end
    return any && ok;
  endfunction

  // one clock: drive, model at the edge, compare at the falling edge
  task automatic cyc(input string tag, input bit tk, input bit wv, input logic [7:0] wa, input logic [7:0] wd);
    bit hit;
    tick = tk; wr_valid = wv; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    hit = tk && model_match();
    if (wv) begin
      if (wa == 8'h01) begin
        m_aie = wd[1];
        if (!wd[3]) m_af = 0;
      end
      if (wa >= 8'h09 && wa <= 8'h0C) m_alm[wa - 8'h09] = wd & (8'h80 | mk[wa - 8'h09]);
    end
    if (hit) m_af = 1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_time(input logic [6:0] mi, input logic [5:0] h, input logic [5:0] d, input logic [2:0] w);
    cur_min = mi; cur_hour = h; cur_date = d; cur_wday = w;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_alm[i] = 8'h80;
    m_af = 0; m_aie = 0;
    @(negedge clk); compare("R1");
    @(negedge clk); rst_n = 1;
    cyc("R1", 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0);
    // R4: everything skipped, strobes never set the flag
    set_time(7'h00, 6'h00, 6'h00, 3'd0);
    cyc("R4", 1, 0, 0, 0);
    set_time(7'h59, 6'h23, 6'h31, 3'd6);
    cyc("R4", 1, 0, 0, 0);
    // R2: slot writes and masking
    cyc("R2", 0, 1, 8'h09, 8'h45);
    cyc("R2", 0, 1, 8'h0A, 8'hFF);
    cyc("R2", 0, 1, 8'h0B, 8'hC0);
    cyc("R2", 0, 1, 8'h0C, 8'h7E);
    // R5 / R3: min 45 and weekday 6 enabled
    set_time(7'h45, 6'h10, 6'h05, 3'd5);
    cyc("R5", 0, 0, 0, 0);
    cyc("R3", 1, 0, 0, 0);
    set_time(7'h45, 6'h10, 6'h05, 3'd6);
    cyc("R5", 0, 0, 0, 0);
    cyc("R3", 1, 0, 0, 0);
    // R6 / R7: write 1 to flag bit keeps it, enable raises the request
    cyc("R6", 0, 1, 8'h01, 8'h0A);
    cyc("R7", 0, 0, 0, 0);
    cyc("R6", 0, 1, 8'h01, 8'h02);
    // R11: set again, then non-matching strobes keep it
    cyc("R11", 1, 0, 0, 0);
    set_time(7'h46, 6'h10, 6'h05, 3'd6);
    cyc("R11", 1, 0, 0, 0);
    cyc("R11", 1, 0, 0, 0);
    // R8: clear and matching strobe together
    set_time(7'h45, 6'h10, 6'h05, 3'd6);
    cyc("R8", 0, 1, 8'h01, 8'h02);
    cyc("R8", 1, 1, 8'h01, 8'h02);
    // R9: slot rewrite and strobe together use the old slot
    cyc("R9", 0, 1, 8'h01, 8'h02);
    cyc("R9", 1, 1, 8'h09, 8'h12);
    cyc("R9", 0, 1, 8'h01, 8'h02);
    set_time(7'h12, 6'h10, 6'h05, 3'd6);
    cyc("R9", 1, 1, 8'h09, 8'h80);
    // R10: foreign addresses change nothing
    cyc("R10", 0, 1, 8'h00, 8'hFF);
    cyc("R10", 0, 1, 8'h05, 8'h00);
    cyc("R10", 0, 1, 8'h0D, 8'h00);
    cyc("R10", 0, 1, 8'hFF, 8'h00);
    // R4: skip all, clear, strobe with any time
    cyc("R4", 0, 1, 8'h0C, 8'hFF);
    cyc("R4", 0, 1, 8'h01, 8'h00);
    cyc("R4", 1, 0, 0, 0);
    // R3: narrowed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, d;
      set_time(7'($urandom_range(0, 2)), 6'($urandom_range(0, 1)),
               6'($urandom_range(0, 1)), 3'($urandom_range(0, 1)));
      a = 8'($urandom_range(0, 13));
      d = 8'($urandom_range(0, 255));
      if (d[7] && $urandom_range(0, 1) == 0) d[7] = 0;
      d[6:0] = d[6:0] & 7'h03;
      if (a == 8'h01) d = 8'($urandom_range(0, 15));
      cyc("R3", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), a, d);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule